// File: doc/BRIEF.md
# Packed BCD Byte Arithmetic Unit

This unit performs decimal arithmetic on one packed-BCD byte, that is, two decimal digits per byte. It supports three operations: add with extend, subtract with extend, and negate with extend. Negate is computed as zero minus the operand minus the extend bit. The operand word is up to 32 bits wide. Only its low byte is rewritten; all higher bits pass through unchanged.

The unit produces the result together with five condition flags:

- extend (X)
- negative (N)
- zero (Z)
- overflow (V)
- carry (C)

Zero is sticky across a multi-byte chain. It can be cleared but never set, so a caller can chain byte operations and test zero at the end.

Digits A to F are legal inputs. They are corrected by fixed bit-level rules, so every byte value gives a defined result and defined flags.

A caller pulses `start_i` with the operands. A single-cycle `done_o` follows after a fixed latency. Results and flags are valid in the cycle where `done_o` is high, and they hold until the next `done_o`.

Top module: `bcd_byte_alu`

## Requirements
- R1: Only bits 7:0 of `res_o` depend on the arithmetic; bits DATA_W-1:8 equal those of `dst_i` captured at start (0x1234567A plus 0x78, X=0 gives 0x12345658).
- R2: Add (`op_i`=00): form the binary sum dst+src+X. Add 0x06 when the low-nibble sum exceeds 9. Add 0x60 when the binary sum exceeds 0x99; that condition also sets C (0x45+0x54+1 gives 0x00 with C; 0xA2+0x19+1 gives 0x22 with C).
- R3: Subtract (`op_i`=01): form the binary difference dst-src-X. Subtract 0x06 when the low nibble borrows. Subtract 0x60 when the whole byte borrows; that borrow sets C (0x34-0x45-1 gives 0x88; 0xA2-0x19-1 gives 0x82 with C clear).
- R4: Negate (`op_i`=10 or 11) computes 0-dst-X with the subtract rules, and `src_i` has no effect (0x7A with X=0 gives 0x20, with X=1 gives 0x1F; 0xFF with X=1 gives 0x9A).
- R5: Z out is Z in AND (result byte == 0). A zero result keeps the incoming Z, and a nonzero result clears it.
- R6: N equals bit 7 of the corrected result byte, and X always equals C.
- R7: V is set for add when bit 7 goes from 0 before correction to 1 after it (0x3E+0x3E+1 gives 0x83 with V). V is set for subtract/negate when bit 7 goes from 1 to 0 (0xA9-0xFF-1 gives 0x43 with V).
- R8: `done_o` rises exactly LATENCY (default 6) rising edges after the edge that samples `start_i`, counting that edge, and lasts one cycle.
- R9: A `start_i` pulse while an operation is in flight is ignored: it neither alters the pending result nor produces an extra `done_o`.
- R10: Result and flags hold between `done_o` pulses. A `start_i` given in the cycle where `done_o` is high is accepted.
- R11: After reset, `res_o`, all flags and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled when idle |
| op_i | input | 2 | 00 add, 01 subtract, 1x negate |
| x_i | input | 1 | Incoming extend flag |
| z_i | input | 1 | Incoming zero flag |
| dst_i | input | DATA_W | Destination word; low byte is the first operand |
| src_i | input | 8 | Source byte (ignored for negate) |
| res_o | output | DATA_W | Destination with low byte replaced |
| x_o | output | 1 | Extend flag out |
| n_o | output | 1 | Negative flag out |
| z_o | output | 1 | Zero flag out |
| v_o | output | 1 | Overflow flag out |
| c_o | output | 1 | Carry/borrow flag out |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can share a cycle: the completion pulse of one operation, and the start strobe of the next. The bench drives a fresh start in the very cycle it observes `done_o`. It then judges two things: the first result must still be presented intact in that cycle, and the second operation must finish exactly six edges later with its own value. A start that lands mid-flight is provoked as well. For that case the pending result must be unchanged and no further completion pulse may appear.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
  typedef enum logic [1:0] {
    BCD_ADD  = 2'b00,
    BCD_SUB  = 2'b01,
    BCD_NEG  = 2'b10,
    BCD_NEG2 = 2'b11
  } bcd_op_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } bcd_flags_t;
endpackage

// File: rtl/bcd_add_byte.sv
module bcd_add_byte (
  input  logic [7:0] a_i,
  input  logic [7:0] b_i,
  input  logic       x_i,
  output logic [7:0] sum_o,
  output logic       carry_o,
  output logic       ovf_o
);
  logic [4:0] lo;
  logic [8:0] bin;
  logic [7:0] s1, s2;
  logic       lo_fix, dec;

  always_comb begin
    lo     = {1'b0, a_i[3:0]} + {1'b0, b_i[3:0]} + {4'b0, x_i};
    bin    = {1'b0, a_i} + {1'b0, b_i} + {8'b0, x_i};
    lo_fix = lo > 5'd9;                 // also covers half carry
    dec    = bin > 9'h099;
    s1     = bin[7:0] + (lo_fix ? 8'h06 : 8'h00);
    s2     = s1 + (dec ? 8'h60 : 8'h00);
    sum_o   = s2;
    carry_o = dec;
    ovf_o   = !bin[7] && s2[7];
  end
endmodule

// File: rtl/bcd_sub_byte.sv
module bcd_sub_byte (
  input  logic [7:0] a_i,
  input  logic [7:0] b_i,
  input  logic       x_i,
  output logic [7:0] diff_o,
  output logic       borrow_o,
  output logic       ovf_o
);
  logic [8:0] bin;
  logic [7:0] d1, d2;
  logic       lo_b;

  always_comb begin
    lo_b = {1'b0, a_i[3:0]} < ({1'b0, b_i[3:0]} + {4'b0, x_i});
    bin  = {1'b0, a_i} - {1'b0, b_i} - {8'b0, x_i};
    d1   = bin[7:0] - (lo_b ? 8'h06 : 8'h00);
    d2   = d1 - (bin[8] ? 8'h60 : 8'h00);
    diff_o   = d2;
    borrow_o = bin[8];
    ovf_o    = bin[7] && !d2[7];
  end
endmodule

// File: rtl/bcd_seq.sv
module bcd_seq #(
  parameter int LATENCY = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic accept_o,
  output logic fire_o
);
  localparam int CNT_W = (LATENCY > 2) ? $clog2(LATENCY) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign accept_o = start_i && (cnt_q == '0);
  assign fire_o   = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (accept_o)    cnt_q <= CNT_W'(LATENCY - 1);
    else if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
  end

  // R9: in-flight count always advances, a new start cannot reload it
  a_r9_busy_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  a_r8_fire_then_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> (cnt_q == '0));
endmodule

// File: rtl/bcd_byte_alu.sv
module bcd_byte_alu
  import bcd_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LATENCY = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic              x_i,
  input  logic              z_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [7:0]        src_i,
  output logic [DATA_W-1:0] res_o,
  output logic              x_o,
  output logic              n_o,
  output logic              z_o,
  output logic              v_o,
  output logic              c_o,
  output logic              done_o
);
  localparam int HI_W = DATA_W - 8;

  logic              accept, fire;
  logic [DATA_W-1:0] dst_q;
  logic [7:0]        src_q;
  bcd_op_e           op_q;
  logic              x_q, z_q;

  logic [7:0] add_a, add_b, sub_a, sub_b, add_s, sub_d, byte_n;
  logic       add_c, add_v, sub_c, sub_v, neg_sel, carry_n, ovf_n;

  logic [DATA_W-1:0] res_q;
  bcd_flags_t        flags_q;
  logic              done_q;

  bcd_seq #(.LATENCY(LATENCY)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .accept_o(accept),
    .fire_o  (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_q <= '0;
      src_q <= '0;
      op_q  <= BCD_ADD;
      x_q   <= 1'b0;
      z_q   <= 1'b0;
    end else if (accept) begin
      dst_q <= dst_i;
      src_q <= src_i;
      op_q  <= bcd_op_e'(op_i);
      x_q   <= x_i;
      z_q   <= z_i;
    end
  end

  assign neg_sel = op_q[1];
  assign add_a   = dst_q[7:0];
  assign add_b   = src_q;
  assign sub_a   = neg_sel ? 8'h00 : dst_q[7:0];
  assign sub_b   = neg_sel ? dst_q[7:0] : src_q;

  bcd_add_byte u_add (
    .a_i(add_a), .b_i(add_b), .x_i(x_q),
    .sum_o(add_s), .carry_o(add_c), .ovf_o(add_v)
  );

  bcd_sub_byte u_sub (
    .a_i(sub_a), .b_i(sub_b), .x_i(x_q),
    .diff_o(sub_d), .borrow_o(sub_c), .ovf_o(sub_v)
  );

  always_comb begin
    if (op_q == BCD_ADD) begin
      byte_n  = add_s;
      carry_n = add_c;
      ovf_n   = add_v;
    end else begin
      byte_n  = sub_d;
      carry_n = sub_c;
      ovf_n   = sub_v;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      flags_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fire;
      if (fire) begin
        res_q     <= {dst_q[DATA_W-1:8], byte_n};
        flags_q.x <= carry_n;
        flags_q.c <= carry_n;
        flags_q.n <= byte_n[7];
        flags_q.v <= ovf_n;
        flags_q.z <= z_q && (byte_n == 8'h00);
      end
    end
  end

  assign res_o  = res_q;
  assign x_o    = flags_q.x;
  assign n_o    = flags_q.n;
  assign z_o    = flags_q.z;
  assign v_o    = flags_q.v;
  assign c_o    = flags_q.c;
  assign done_o = done_q;

  a_r1_upper_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (res_o[DATA_W-1:8] == dst_q[DATA_W-1:8]));

  a_r5_z_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!z_o || (z_q && res_o[7:0] == 8'h00)));

  a_r6_x_tracks_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_o == c_o);

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(res_o) && $stable(flags_q)));

  initial a_r1_width: assert (HI_W > 0);
endmodule

// File: tb/bcd_byte_alu_test.sv
module bcd_byte_alu_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic        x_i = 1'b0, z_i = 1'b0;
  logic [31:0] dst_i = '0;
  logic [7:0]  src_i = '0;
  logic [31:0] res_o;
  logic        x_o, n_o, z_o, v_o, c_o, done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10ns clk_i = ~clk_i;

  bcd_byte_alu #(.DATA_W(32), .LATENCY(6)) uut (
    .clk_i, .rst_ni, .start_i, .op_i, .x_i, .z_i, .dst_i, .src_i,
    .res_o, .x_o, .n_o, .z_o, .v_o, .c_o, .done_o
  );

  function automatic logic [4:0] flags();
    return {x_o, n_o, z_o, v_o, c_o};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [1:0] op, input logic [31:0] dst,
                        input logic [7:0] src, input logic x, input logic z);
    op_i = op; dst_i = dst; src_i = src; x_i = x; z_i = z;
    start_i = 1'b1;
  endtask

  // R8: done must appear on the 6th negedge after launch, not before
  task automatic await_done(input string req);
    logic early = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk_i);
      if (i == 1) start_i = 1'b0;
      if (i < 6 && done_o) early = 1'b1;
    end
    check({req, " R8"}, "latency early/done", {30'b0, early, done_o}, 32'h1);
  endtask

  // flags vector order {x,n,z,v,c}; R6 checked through it
  task automatic run_op(input string req, input logic [1:0] op,
                        input logic [31:0] dst, input logic [7:0] src,
                        input logic x, input logic z,
                        input logic [31:0] exp_res, input logic [4:0] exp_fl);
    @(negedge clk_i);
    launch(op, dst, src, x, z);
    await_done(req);
    check(req, "result", res_o, exp_res);
    check({req, " R6"}, "flags xnzvc", {27'b0, flags()}, {27'b0, exp_fl});
  endtask

  task automatic t_reset();
    check("R11", "result", res_o, 32'h0);
    check("R11", "flags+done", {26'b0, flags(), done_o}, 32'h0);
  endtask

  task automatic t_upper_pass();
    run_op("R1", 2'b00, 32'h1234567A, 8'h78, 0, 0, 32'h12345658, 5'b10001);
    run_op("R1", 2'b01, 32'hDEADBE89, 8'h78, 0, 0, 32'hDEADBE11, 5'b00000);
  endtask

  task automatic t_add();
    run_op("R2", 2'b00, 32'h12345645, 8'h54, 0, 1, 32'h12345699, 5'b01000);
    run_op("R2", 2'b00, 32'h12345645, 8'h54, 1, 0, 32'h12345600, 5'b10001);
    run_op("R2", 2'b00, 32'h000000A2, 8'h19, 1, 0, 32'h00000022, 5'b10001);
  endtask

  task automatic t_sub();
    run_op("R3", 2'b01, 32'h12345689, 8'h78, 0, 1, 32'h12345611, 5'b00000);
    run_op("R3", 2'b01, 32'h12345634, 8'h45, 1, 0, 32'h12345688, 5'b11001);
    run_op("R3", 2'b01, 32'h000000A2, 8'h19, 1, 0, 32'h00000082, 5'b01000);
  endtask

  task automatic t_neg();
    run_op("R4", 2'b10, 32'h0000007A, 8'h33, 0, 0, 32'h00000020, 5'b10011);
    run_op("R4", 2'b10, 32'h1234567A, 8'hC5, 1, 1, 32'h1234561F, 5'b10011);
    run_op("R4", 2'b10, 32'h123456FF, 8'h00, 1, 1, 32'h1234569A, 5'b11001);
    run_op("R4", 2'b11, 32'h00000001, 8'h99, 0, 0, 32'h00000099, 5'b11001);
  endtask

  task automatic t_z_sticky();
    run_op("R5", 2'b00, 32'h12345600, 8'h00, 0, 1, 32'h12345600, 5'b00100);
    run_op("R5", 2'b01, 32'h123456FF, 8'hFF, 0, 1, 32'h12345600, 5'b00100);
    run_op("R5", 2'b10, 32'h12345600, 8'h42, 0, 1, 32'h12345600, 5'b00100);
    run_op("R5", 2'b10, 32'h12345600, 8'h42, 0, 0, 32'h12345600, 5'b00000);
  endtask

  task automatic t_overflow();
    run_op("R7", 2'b00, 32'h1234563E, 8'h3E, 1, 0, 32'h12345683, 5'b01010);
    run_op("R7", 2'b01, 32'h123456A9, 8'hFF, 1, 0, 32'h12345643, 5'b10011);
  endtask

  task automatic t_busy_ignore();
    logic extra = 1'b0;
    logic moved = 1'b0;
    @(negedge clk_i);
    launch(2'b00, 32'h00000010, 8'h20, 0, 0);
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk_i);
      if (i == 1) start_i = 1'b0;
      if (i == 2) launch(2'b01, 32'h00000099, 8'h11, 1, 1);
      if (i == 3) start_i = 1'b0;
    end
    check("R9", "done at 6", {31'b0, done_o}, 32'h1);
    check("R9", "result", res_o, 32'h00000030);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      if (done_o) extra = 1'b1;
      if (res_o !== 32'h00000030 || flags() !== 5'b00000) moved = 1'b1;
    end
    check("R9", "extra done", {31'b0, extra}, 32'h0);
    check("R10", "hold moved", {31'b0, moved}, 32'h0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk_i);
    launch(2'b00, 32'h00000001, 8'h01, 0, 0);
    await_done("R10");
    check("R10", "first result", res_o, 32'h00000002);
    launch(2'b01, 32'h00000050, 8'h01, 0, 0);   // start in done cycle
    await_done("R10");
    check("R10", "second result", res_o, 32'h00000049);
    check("R10", "second flags", {27'b0, flags()}, 32'h0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_upper_pass();
    t_add();
    t_sub();
    t_neg();
    t_z_sticky();
    t_overflow();
    t_busy_ignore();
    t_back_to_back();
    finish_run();
  end

  initial begin
    #2ms;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end
endmodule